// File: doc/BRIEF.md
# Window Watchdog Monitor

This block watches a periodic heartbeat from software or a processor. Every falling edge on `wdi` is a kick. After monitoring starts, the first kick only has to arrive before an upper limit. Every later kick has to land strictly inside a window measured from the kick before it. A kick that comes too soon, or a missing kick, is a fault. The fault drives the active-low output `wdo_n` low for a fixed hold period. `fault_cause` records whether the most recent fault was early or late.

The window limits come from one of three sources, picked by `tsel`: a slow preset pair, a fast preset pair, or a pair driven on `ext_lo`/`ext_hi`. Monitoring stops while the system reset input `sys_rst_n` is low or while `wd_en` is low. In both cases `wdi` is ignored and `wdo_n` stays high. When monitoring starts again, a setup blackout passes before kicks are looked at. All times are parameters counted in clock cycles. `wdi` may be asynchronous.

Top module: `win_watchdog`

## Requirements
- R1: Only a high-to-low transition of `wdi` is a kick. A low-to-high transition never causes a fault and never restarts the window.
- R2: The first kick after monitoring begins, and the first kick after a fault ends, is checked only against the upper bound HI. Any count below HI is accepted, even one at or below LO. If no kick arrives within HI cycles of the start of monitoring, a late fault follows.
- R3: For a later kick, G is the number of cycles between its arrival at `wdi` and the arrival of the previous kick. The kick is accepted when LO < G < HI. When G <= LO it is an early fault, and `fault_cause` becomes 0.
- R4: If HI cycles pass after a kick with no new kick, a late fault follows and `fault_cause` becomes 1. A kick at exactly G = HI is late.
- R5: A fault holds `wdo_n` low for exactly FAULT_LEN cycles. Monitoring then restarts in first-kick mode.
- R6: While `sys_rst_n` is low, `wdo_n` is high from the next clock edge on, even in the middle of a fault, and `wdi` is ignored. When `sys_rst_n` is released, monitoring restarts through the setup blackout.
- R7: While `wd_en` is low, `wdo_n` is high from the next clock edge on and `wdi` is ignored. When `wd_en` rises, monitoring restarts through the setup blackout.
- R8: For SETUP_LEN cycles after monitoring is activated, kicks are ignored. The first-kick upper bound is counted from the end of this blackout, so a late fault shows SETUP_LEN + HI cycles after activation.
- R9: `tsel` = 2'b00 selects the slow preset pair, 2'b01 selects the fast preset pair, and 2'b10 or 2'b11 selects `ext_lo`/`ext_hi`.
- R10: `wdi` passes through a two-flop synchroniser. A kick therefore takes effect on the third rising clock edge after `wdi` is driven low, and a fault it causes shows on `wdo_n` right after that edge. After `rst_n`, `wdo_n` is 1 and `fault_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| sys_rst_n | input | 1 | System reset level; low holds the watchdog idle |
| wd_en | input | 1 | Watchdog enable; low disables monitoring |
| wdi | input | 1 | Heartbeat input, asynchronous; falling edges are kicks |
| tsel | input | 2 | Timing source select |
| ext_lo | input | CNT_W | External lower window bound in cycles |
| ext_hi | input | CNT_W | External upper window bound in cycles |
| wdo_n | output | 1 | Active-low watchdog fault output |
| fault_cause | output | 1 | Cause of the latest fault: 0 early, 1 late |

## Verification
Every result is due at a fixed cycle offset that the bench derives from its own stimulus times:
- A kick driven low at a falling clock edge acts on the third rising edge after it. An early fault therefore shows at the third falling edge after the drive.
- A late fault shows HI + 3 falling edges after the last kick drive.
- A start from idle shows a late fault SETUP_LEN + HI + 1 falling edges after activation.
- `wdo_n` rises again FAULT_LEN cycles after it fell.

The bench samples one cycle before and one cycle after each of these edges. An output that is one cycle early or one cycle late is therefore caught in either direction.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_FIRST  = 3'd2,
        ST_WINDOW = 3'd3,
        ST_FAULT  = 3'd4
    } wd_state_e;

    typedef enum logic {
        CAUSE_EARLY = 1'b0,
        CAUSE_LATE  = 1'b1
    } cause_e;

    typedef enum logic [1:0] {
        TSEL_SLOW = 2'b00,
        TSEL_FAST = 2'b01,
        TSEL_EXTA = 2'b10,
        TSEL_EXTB = 2'b11
    } tsel_e;

endpackage

// File: rtl/wwdt_edge_sync.sv
module wwdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R1
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/wwdt_bounds.sv
module wwdt_bounds
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SLOW_LO = 40,
    parameter int SLOW_HI = 80,
    parameter int FAST_LO = 6,
    parameter int FAST_HI = 33
) (
    input  logic [1:0]       tsel,
    input  logic [CNT_W-1:0] ext_lo,
    input  logic [CNT_W-1:0] ext_hi,
    output logic [CNT_W-1:0] win_lo,
    output logic [CNT_W-1:0] win_hi
);

    localparam logic [CNT_W-1:0] SLO = CNT_W'(SLOW_LO);
    localparam logic [CNT_W-1:0] SHI = CNT_W'(SLOW_HI);
    localparam logic [CNT_W-1:0] FLO = CNT_W'(FAST_LO);
    localparam logic [CNT_W-1:0] FHI = CNT_W'(FAST_HI);

    always_comb begin
        case (tsel_e'(tsel))
            TSEL_SLOW: begin win_lo = SLO;    win_hi = SHI;    end
            TSEL_FAST: begin win_lo = FLO;    win_hi = FHI;    end
            default:   begin win_lo = ext_lo; win_hi = ext_hi; end
        endcase
    end

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SETUP_LEN = 12,
    parameter int FAULT_LEN = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst_n,
    input  logic             wd_en,
    input  logic             kick,
    input  logic [CNT_W-1:0] win_lo,
    input  logic [CNT_W-1:0] win_hi,
    output logic             wdo_n,
    output logic             cause
);

    localparam int AUX_MAX = (SETUP_LEN > FAULT_LEN) ? SETUP_LEN : FAULT_LEN;
    localparam int AUX_W   = $clog2(AUX_MAX + 1);
    localparam logic [AUX_W-1:0] SETUP_END = AUX_W'(SETUP_LEN);
    localparam logic [AUX_W-1:0] FAULT_END = AUX_W'(FAULT_LEN);

    typedef struct packed {
        wd_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [AUX_W-1:0] aux;
        logic             wdo_n;
        cause_e           cause;
    } core_t;

    core_t r_d, r_q;
    logic  active;

    assign active = sys_rst_n & wd_en;

    always_comb begin
        r_d = r_q;
        if (!active) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.aux   = '0;
            r_d.wdo_n = 1'b1;
        end else begin
            case (r_q.state)
                ST_IDLE: begin
                    r_d.state = ST_SETUP;
                    r_d.aux   = AUX_W'(1);
                end
                ST_SETUP: begin
                    if (r_q.aux >= SETUP_END) begin
                        r_d.state = ST_FIRST;
                        r_d.cnt   = CNT_W'(1);
                    end else begin
                        r_d.aux = r_q.aux + AUX_W'(1);
                    end
                end
                ST_FIRST, ST_WINDOW: begin
                    if (r_q.cnt >= win_hi) begin
                        r_d.state = ST_FAULT;
                        r_d.aux   = AUX_W'(1);
                        r_d.cnt   = '0;
                        r_d.wdo_n = 1'b0;
                        r_d.cause = CAUSE_LATE;
                    end else if (kick) begin
                        if (r_q.state == ST_WINDOW && r_q.cnt <= win_lo) begin
                            r_d.state = ST_FAULT;
                            r_d.aux   = AUX_W'(1);
                            r_d.cnt   = '0;
                            r_d.wdo_n = 1'b0;
                            r_d.cause = CAUSE_EARLY;
                        end else begin
                            r_d.state = ST_WINDOW;
                            r_d.cnt   = CNT_W'(1);
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_FAULT: begin
                    if (r_q.aux >= FAULT_END) begin
                        r_d.state = ST_FIRST;
                        r_d.cnt   = CNT_W'(1);
                        r_d.aux   = '0;
                        r_d.wdo_n = 1'b1;
                    end else begin
                        r_d.aux = r_q.aux + AUX_W'(1);
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.wdo_n = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, aux: '0, wdo_n: 1'b1, cause: CAUSE_EARLY};
        end else begin
            r_q <= r_d;
        end
    end

    assign wdo_n = r_q.wdo_n;
    assign cause = r_q.cause;

    // R6
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> wdo_n);

    // R7
    en_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> wdo_n);

    // R8
    setup_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SETUP && kick) |=> wdo_n);

    // R3
    early_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && kick && r_q.state == ST_WINDOW && r_q.cnt <= win_lo && r_q.cnt < win_hi)
        |=> (!wdo_n && cause == CAUSE_EARLY));

    // R4
    late_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (r_q.state == ST_FIRST || r_q.state == ST_WINDOW) && r_q.cnt >= win_hi)
        |=> (!wdo_n && cause == CAUSE_LATE));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && r_q.state == ST_FAULT && r_q.aux < FAULT_END) |=> !wdo_n);

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
    parameter int CNT_W     = 16,
    parameter int SLOW_LO   = 40,
    parameter int SLOW_HI   = 80,
    parameter int FAST_LO   = 6,
    parameter int FAST_HI   = 33,
    parameter int SETUP_LEN = 12,
    parameter int FAULT_LEN = 20,
    parameter int SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst_n,
    input  logic             wd_en,
    input  logic             wdi,
    input  logic [1:0]       tsel,
    input  logic [CNT_W-1:0] ext_lo,
    input  logic [CNT_W-1:0] ext_hi,
    output logic             wdo_n,
    output logic             fault_cause
);

    logic             kick;
    logic [CNT_W-1:0] win_lo;
    logic [CNT_W-1:0] win_hi;

    wwdt_edge_sync #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wdi),
        .fall  (kick)
    );

    wwdt_bounds #(
        .CNT_W   (CNT_W),
        .SLOW_LO (SLOW_LO),
        .SLOW_HI (SLOW_HI),
        .FAST_LO (FAST_LO),
        .FAST_HI (FAST_HI)
    ) u_bounds (
        .tsel   (tsel),
        .ext_lo (ext_lo),
        .ext_hi (ext_hi),
        .win_lo (win_lo),
        .win_hi (win_hi)
    );

    wwdt_core #(
        .CNT_W     (CNT_W),
        .SETUP_LEN (SETUP_LEN),
        .FAULT_LEN (FAULT_LEN)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_rst_n (sys_rst_n),
        .wd_en     (wd_en),
        .kick      (kick),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .wdo_n     (wdo_n),
        .cause     (fault_cause)
    );

endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb;

    localparam int CW    = 16;
    localparam int S_LO  = 40;
    localparam int S_HI  = 80;
    localparam int F_LO  = 6;
    localparam int F_HI  = 33;
    localparam int X_LO  = 10;
    localparam int X_HI  = 20;
    localparam int SETUP = 12;
    localparam int FLEN  = 20;

    localparam logic [1:0] EXP_OK    = 2'd0;
    localparam logic [1:0] EXP_EARLY = 2'd1;
    localparam logic [1:0] EXP_LATE  = 2'd2;

    typedef struct packed {
        logic [1:0] tsel;
        logic [7:0] gap;
        logic [1:0] exp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'd41, EXP_OK},
        '{2'd0, 8'd79, EXP_OK},
        '{2'd0, 8'd40, EXP_EARLY},
        '{2'd0, 8'd8,  EXP_EARLY},
        '{2'd0, 8'd0,  EXP_LATE},
        '{2'd1, 8'd7,  EXP_OK},
        '{2'd1, 8'd32, EXP_OK},
        '{2'd1, 8'd6,  EXP_EARLY},
        '{2'd1, 8'd0,  EXP_LATE},
        '{2'd2, 8'd11, EXP_OK},
        '{2'd2, 8'd19, EXP_OK},
        '{2'd2, 8'd10, EXP_EARLY},
        '{2'd2, 8'd0,  EXP_LATE},
        '{2'd3, 8'd15, EXP_OK}
    };

    logic          clk = 1'b0;
    logic          rst_n, sys_rst_n, wd_en, wdi;
    logic [1:0]    tsel;
    logic [CW-1:0] ext_lo, ext_hi;
    logic          wdo_n, fault_cause;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    win_watchdog #(
        .CNT_W (CW), .SLOW_LO (S_LO), .SLOW_HI (S_HI),
        .FAST_LO (F_LO), .FAST_HI (F_HI),
        .SETUP_LEN (SETUP), .FAULT_LEN (FLEN), .SYNC_STG (2)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .sys_rst_n (sys_rst_n), .wd_en (wd_en),
        .wdi (wdi), .tsel (tsel), .ext_lo (ext_lo), .ext_hi (ext_hi),
        .wdo_n (wdo_n), .fault_cause (fault_cause)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired: run hung (act=%0d exp<150000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%b expected=%b at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // drive a falling edge now, raise wdi two cycles later
    task automatic pulse();
        wdi = 1'b0;
        step(2);
        wdi = 1'b1;
    endtask

    function automatic int hi_of(logic [1:0] t);
        return (t == 2'd0) ? S_HI : (t == 2'd1) ? F_HI : X_HI;
    endfunction

    task automatic activate(logic [1:0] t);
        wd_en = 1'b0;
        step(2);
        tsel  = t;
        wd_en = 1'b1;
    endtask

    task automatic check_fault_len(string tag);
        step(FLEN - 1);
        check({tag, " R5 still low"}, wdo_n, 1'b0);
        step(1);
        check({tag, " R5 released"}, wdo_n, 1'b1);
    endtask

    task automatic run_vec(int idx);
        vec_t v;
        int   hi;
        string tag;
        v   = VECS[idx];
        hi  = hi_of(v.tsel);
        tag = $sformatf("R9 vec%0d", idx);
        activate(v.tsel);
        step(SETUP + 2);
        pulse();                         // first kick: gap 4 into first-kick mode, R2
        if (v.exp == EXP_LATE) begin
            step(hi);
            check({tag, " R4 before"}, wdo_n, 1'b1);
            step(1);
            check({tag, " R4 late"}, wdo_n, 1'b0);
            check({tag, " R4 cause"}, fault_cause, 1'b1);
            check_fault_len(tag);
        end else begin
            step(int'(v.gap) - 2);
            pulse();
            check({tag, " R10 before"}, wdo_n, 1'b1);
            step(1);
            if (v.exp == EXP_OK) begin
                check({tag, " R3 accepted"}, wdo_n, 1'b1);
            end else begin
                check({tag, " R3 early"}, wdo_n, 1'b0);
                check({tag, " R3 cause"}, fault_cause, 1'b0);
                check_fault_len(tag);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; sys_rst_n = 1'b1; wd_en = 1'b0; wdi = 1'b1;
        tsel = 2'd0; ext_lo = CW'(X_LO); ext_hi = CW'(X_HI);
        step(3);
        check("R10 reset wdo_n", wdo_n, 1'b1);
        check("R10 reset cause", fault_cause, 1'b0);
        rst_n = 1'b1;
        step(1);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R1: rising edge below LO has no effect, later falling edge accepted
        activate(2'd1);
        step(SETUP + 2);
        wdi = 1'b0;
        step(4);
        wdi = 1'b1;
        step(3);
        check("R1 rising edge ignored", wdo_n, 1'b1);
        step(3);
        wdi = 1'b0;
        step(3);
        check("R1 falling edge accepted", wdo_n, 1'b1);
        wdi = 1'b1;

        // R8 / R2: kick in blackout ignored, late fault at SETUP+HI+1
        activate(2'd1);
        step(2);
        pulse();
        step(SETUP + F_HI - 4);
        check("R8 R2 before first-late", wdo_n, 1'b1);
        step(1);
        check("R8 R2 first-late", wdo_n, 1'b0);
        check("R8 R2 cause", fault_cause, 1'b1);

        // R5: after the fault, first-kick mode then window mode
        step(FLEN);
        check("R5 fault over", wdo_n, 1'b1);
        pulse();
        step(1);
        check("R5 first kick below LO accepted", wdo_n, 1'b1);
        step(1);
        pulse();
        step(1);
        check("R5 window early", wdo_n, 1'b0);
        check("R5 window early cause", fault_cause, 1'b0);

        // R6: system reset clears fault, ignores kicks, restarts with setup
        sys_rst_n = 1'b0;
        step(1);
        check("R6 wdo_n released", wdo_n, 1'b1);
        pulse();
        step(4);
        pulse();
        step(F_HI + 5);
        check("R6 kicks ignored", wdo_n, 1'b1);
        sys_rst_n = 1'b1;
        step(SETUP + F_HI);
        check("R6 restart before late", wdo_n, 1'b1);
        step(1);
        check("R6 restart late", wdo_n, 1'b0);

        // R7: disable clears fault, ignores kicks
        wd_en = 1'b0;
        step(1);
        check("R7 wdo_n released", wdo_n, 1'b1);
        pulse();
        step(4);
        pulse();
        step(F_HI + 5);
        check("R7 kicks ignored", wdo_n, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule